// File: doc/BRIEF.md
# Dual-Timing Parallel Host Register Port

This block is a slave-only parallel port through which an external microcontroller reads and writes a small bank of configuration registers. It accepts either of two bus timings. In separate-strobe timing the host drives a read strobe and a write strobe. In single-strobe timing the host drives one data strobe plus a direction select. Both timings share the same pins.

The timing is chosen by strap inputs. Their value is latched while reset is held, and the value present in the last reset cycle stays in force until the next reset. All host control pins are synchronised to the core clock before they are decoded. A write takes effect once, when its strobe is released. The port never starts a bus cycle of its own. The core can still post a word into a mailbox register, which raises a request line asking the host to come and read it.

The address selects one of eight registers:
- Addresses 0 to 5 are read/write configuration words, presented to the core on `cfg_o`.
- Address 6 returns the latched strap value.
- Address 7 returns the mailbox word.

Top module: `hpi_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `cfg_o` is all zero, `hreq` is 0 and `hdata_oe` is 0. After reset the mailbox reads as 0.
- R2: The `strap_i` value present in the last cycle of reset is latched. Bit 0 = 1 selects single-strobe timing and 0 selects separate-strobe timing. Later changes of `strap_i` have no effect. Reading address 6 returns the latched straps zero-extended.
- R3: Separate-strobe write: `hcs_n`=0 and `hstb1` (write strobe, active low) low with `hstb0_n` high, then `hstb1` high. This stores `hdata_i` in register `haddr` (0..5), byte `haddr` of `cfg_o` (bits 8*a+7..8*a).
- R4: Separate-strobe read: `hcs_n`=0 and `hstb0_n` low with `hstb1` high. This drives `hdata_oe`=1 and `hdata_o` = contents of register `haddr`.
- R5: Single-strobe timing: `hcs_n`=0 and `hstb0_n` (data strobe) low start an access. `hstb1`=1 is a read with the same data result as R4. `hstb1`=0 is a write that stores `hdata_i` when `hstb0_n` rises.
- R6: In single-strobe timing, driving `hstb1` low and back high while `hstb0_n` stays high changes no register.
- R7: `hdata_oe` is 0 whenever no read is in progress, including during a write.
- R8: Host writes to addresses 6 and 7 are ignored; the values read back there are unchanged.
- R9: A one-cycle `post_vld` loads `post_data` into the mailbox and sets `hreq`. `hreq` returns to 0 after a host read of address 7 ends. A read of any other address leaves it set.
- R10: With `hcs_n` high, strobe activity causes no write and no read drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 5 | Strap inputs, latched during reset |
| hcs_n | input | 1 | Host chip select, active low |
| hstb0_n | input | 1 | Read strobe or data strobe, active low |
| hstb1 | input | 1 | Write strobe (active low) or read/write select (1 = read) |
| haddr | input | 3 | Register address |
| hdata_i | input | 8 | Host write data |
| hdata_o | output | 8 | Host read data |
| hdata_oe | output | 1 | Read data output enable |
| hreq | output | 1 | Request to the host to read the mailbox |
| post_vld | input | 1 | Core posts a mailbox word |
| post_data | input | 8 | Mailbox word from the core |
| cfg_o | output | 48 | Six configuration registers, register a in bits 8*a+7..8*a |
| moto_mode_o | output | 1 | 1 when single-strobe timing is latched |

## Verification
The test sweeps every address with writes and read-backs under both latched timings. Each address gets a distinct data value, so a swapped address or a mode-dependent decode fault shows as a mismatch. Writes to the read-only addresses and strobes without chip select are checked against unchanged read-backs and `cfg_o`. In single-strobe mode, a bare direction toggle confirms that the select line alone never writes. Mailbox reads are compared with reads of other addresses to tell whether the request clear is tied to the mailbox address. The strap inputs are changed after reset to show that the latched mode holds.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int SW  = 5;
  localparam int NREG = 1 << AW;
  localparam int NCFG = NREG - 2;
  localparam logic [AW-1:0] ADDR_STRAP = AW'(NCFG);
  localparam logic [AW-1:0] ADDR_MBOX  = AW'(NCFG + 1);

  typedef enum logic {
    BUS_SPLIT  = 1'b0,
    BUS_SINGLE = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hpi_decode.sv
module hpi_decode
  import hpi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bus_mode_e mode_i,
  input  logic      cs_n_s,
  input  logic      stb0_n_s,
  input  logic      stb1_s,
  output logic      rd_act_o,
  output logic      wr_act_o,
  output logic      rd_fall_o,
  output logic      wr_fall_o
);
  logic rd_act, wr_act, rd_q, wr_q;

  always_comb begin
    rd_act = 1'b0;
    wr_act = 1'b0;
    if (!cs_n_s) begin
      if (mode_i == BUS_SINGLE) begin
        rd_act = !stb0_n_s && stb1_s;
        wr_act = !stb0_n_s && !stb1_s;
      end else begin
        rd_act = !stb0_n_s && stb1_s;
        wr_act = stb0_n_s && !stb1_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_act_o  = rd_act;
  assign wr_act_o  = wr_act;
  assign rd_fall_o = rd_q && !rd_act;
  assign wr_fall_o = wr_q && !wr_act;

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q));
endmodule

// File: rtl/hpi_regfile.sv
module hpi_regfile
  import hpi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_act_i,
  input  logic               wr_act_i,
  input  logic               rd_fall_i,
  input  logic               wr_fall_i,
  input  logic [AW-1:0]      haddr,
  input  logic [DW-1:0]      hdata_i,
  input  logic [SW-1:0]      strap_q,
  input  logic               post_vld,
  input  logic [DW-1:0]      post_data,
  output logic [NCFG*DW-1:0] cfg_o,
  output logic [DW-1:0]      hdata_o,
  output logic               hdata_oe,
  output logic               hreq
);
  logic [DW-1:0] cfg_q [NCFG];
  logic [DW-1:0] mbox_q;
  logic [AW-1:0] w_addr, r_addr;
  logic [DW-1:0] w_data, rmux;
  logic          req_q, oe_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_addr <= '0;
      w_data <= '0;
      r_addr <= '0;
    end else begin
      if (wr_act_i) begin
        w_addr <= haddr;
        w_data <= hdata_i;
      end
      if (rd_act_i) r_addr <= haddr;
    end
  end

  generate
    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst) cfg_q[i] <= '0;
        else if (wr_fall_i && w_addr == AW'(i)) cfg_q[i] <= w_data;
      end
      assign cfg_o[i*DW +: DW] = cfg_q[i];
    end
  endgenerate

  always_comb begin
    rmux = mbox_q;
    if (haddr == ADDR_STRAP) rmux = DW'(strap_q);
    for (int i = 0; i < NCFG; i++)
      if (haddr == AW'(i)) rmux = cfg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mbox_q  <= '0;
      req_q   <= 1'b0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      oe_q <= rd_act_i;
      if (rd_act_i) rdata_q <= rmux;
      if (post_vld) begin
        mbox_q <= post_data;
        req_q  <= 1'b1;
      end else if (rd_fall_i && r_addr == ADDR_MBOX) begin
        req_q <= 1'b0;
      end
    end
  end

  assign hdata_o  = rdata_q;
  assign hdata_oe = oe_q;
  assign hreq     = req_q;

  p_cfg_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cfg_o)) |-> $past(wr_fall_i));

  p_req_set_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(hreq)) |-> $past(post_vld));

  p_req_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(hreq)) |-> $past(rd_fall_i && r_addr == ADDR_MBOX));
endmodule

// File: rtl/hpi_top.sv
module hpi_top
  import hpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SW-1:0]      strap_i,
  input  logic               hcs_n,
  input  logic               hstb0_n,
  input  logic               hstb1,
  input  logic [AW-1:0]      haddr,
  input  logic [DW-1:0]      hdata_i,
  output logic [DW-1:0]      hdata_o,
  output logic               hdata_oe,
  output logic               hreq,
  input  logic               post_vld,
  input  logic [DW-1:0]      post_data,
  output logic [NCFG*DW-1:0] cfg_o,
  output logic               moto_mode_o
);
  logic [SW-1:0] strap_q;
  logic [2:0]    ctl_s;
  logic          rd_act, wr_act, rd_fall, wr_fall;
  bus_mode_e     mode;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  assign mode        = bus_mode_e'(strap_q[0]);
  assign moto_mode_o = strap_q[0];

  hpi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({hcs_n, hstb0_n, hstb1}),
    .q_o (ctl_s)
  );

  hpi_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode),
    .cs_n_s    (ctl_s[2]),
    .stb0_n_s  (ctl_s[1]),
    .stb1_s    (ctl_s[0]),
    .rd_act_o  (rd_act),
    .wr_act_o  (wr_act),
    .rd_fall_o (rd_fall),
    .wr_fall_o (wr_fall)
  );

  hpi_regfile u_rf (
    .clk       (clk),
    .rst       (rst),
    .rd_act_i  (rd_act),
    .wr_act_i  (wr_act),
    .rd_fall_i (rd_fall),
    .wr_fall_i (wr_fall),
    .haddr     (haddr),
    .hdata_i   (hdata_i),
    .strap_q   (strap_q),
    .post_vld  (post_vld),
    .post_data (post_data),
    .cfg_o     (cfg_o),
    .hdata_o   (hdata_o),
    .hdata_oe  (hdata_oe),
    .hreq      (hreq)
  );

  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q));

  p_oe_cs_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hdata_oe) |-> $past(!ctl_s[2]));
endmodule

// File: tb/hpi_top_tb.sv
module hpi_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  strap_i = '0;
  logic hcs_n = 1'b1, hstb0_n = 1'b1, hstb1 = 1'b1;
  logic [2:0]  haddr = '0;
  logic [7:0]  hdata_i = '0;
  logic [7:0]  hdata_o;
  logic        hdata_oe, hreq, moto;
  logic        post_vld = 1'b0;
  logic [7:0]  post_data = '0;
  logic [47:0] cfg_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_cfg [6];
  logic [7:0] m_mbox;
  logic [4:0] m_strap;

  always #4 clk = ~clk;

  hpi_top dut_i (
    .clk(clk), .rst(rst), .strap_i(strap_i), .hcs_n(hcs_n), .hstb0_n(hstb0_n),
    .hstb1(hstb1), .haddr(haddr), .hdata_i(hdata_i), .hdata_o(hdata_o),
    .hdata_oe(hdata_oe), .hreq(hreq), .post_vld(post_vld), .post_data(post_data),
    .cfg_o(cfg_o), .moto_mode_o(moto)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] expect_rd(input logic [2:0] a);
    if (a < 3'd6) return m_cfg[a];
    if (a == 3'd6) return {3'b000, m_strap};
    return m_mbox;
  endfunction

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst = 1'b1; strap_i = s;
    idle(3);
    check("R1 oe in reset", hdata_oe, 0);
    rst = 1'b0;
    strap_i = ~s;
    for (int i = 0; i < 6; i++) m_cfg[i] = '0;
    m_mbox = '0; m_strap = s;
    @(negedge clk);
    check("R1 cfg after reset", cfg_o, 0);
    check("R1 hreq after reset", hreq, 0);
    check("R1 oe after reset", hdata_oe, 0);
    check("R2 mode latched", moto, s[0]);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d, input bit cs);
    haddr = a; hdata_i = d;
    if (moto) begin
      hstb1 = 1'b0; hcs_n = !cs; idle(1);
      hstb0_n = 1'b0; idle(4);
      check("R7 oe low during write", hdata_oe, 0);
      hstb0_n = 1'b1; idle(4);
    end else begin
      hcs_n = !cs; idle(1);
      hstb1 = 1'b0; idle(4);
      check("R7 oe low during write", hdata_oe, 0);
      hstb1 = 1'b1; idle(4);
    end
    hcs_n = 1'b1; hstb1 = 1'b1; idle(2);
    if (cs && a < 3'd6) m_cfg[a] = d;
  endtask

  task automatic host_read(input logic [2:0] a, input string req);
    haddr = a; hstb1 = 1'b1;
    hcs_n = 1'b0; idle(1);
    hstb0_n = 1'b0; idle(5);
    check(req, {hdata_oe, hdata_o}, {1'b1, expect_rd(a)});
    hstb0_n = 1'b1; idle(1);
    hcs_n = 1'b1; idle(4);
    check("R7 oe low after read", hdata_oe, 0);
  endtask

  task automatic sweep(input int seed);
    for (int a = 0; a < 8; a++)
      host_write(3'(a), 8'((a * 37 + seed * 11 + 5) & 255), 1'b1);
    for (int a = 0; a < 6; a++)
      check("R3/R5 cfg_o byte", cfg_o[a*8 +: 8], m_cfg[a]);
    for (int a = 0; a < 8; a++)
      host_read(3'(a), a >= 6 ? "R8 read-only readback" : (moto ? "R5 readback" : "R4 readback"));
  endtask

  task automatic post(input logic [7:0] d);
    @(negedge clk);
    post_vld = 1'b1; post_data = d;
    @(negedge clk);
    post_vld = 1'b0;
    m_mbox = d;
  endtask

  task automatic mailbox_test(input logic [7:0] d);
    post(d);
    check("R9 hreq set", hreq, 1);
    host_read(3'd2, "R9 other read");
    check("R9 hreq kept after other read", hreq, 1);
    host_read(3'd7, "R9 mailbox read");
    check("R9 hreq cleared", hreq, 0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // separate-strobe timing
    do_reset(5'b10110);
    host_read(3'd6, "R2 strap readback");
    sweep(1);
    host_write(3'd1, 8'hA5, 1'b0);
    check("R10 no write without cs", cfg_o[15:8], m_cfg[1]);
    haddr = 3'd3; hcs_n = 1'b1; hstb0_n = 1'b0; idle(5);
    check("R10 no drive without cs", hdata_oe, 0);
    hstb0_n = 1'b1; idle(3);
    mailbox_test(8'h3C);
    // single-strobe timing
    do_reset(5'b01011);
    host_read(3'd6, "R2 strap readback");
    check("R2 strap change ignored", moto, 1);
    sweep(2);
    haddr = 3'd4; hdata_i = 8'hEE; hcs_n = 1'b0; idle(1);
    hstb1 = 1'b0; idle(4); hstb1 = 1'b1; idle(4); hcs_n = 1'b1; idle(2);
    check("R6 select toggle no write", cfg_o[39:32], m_cfg[4]);
    host_read(3'd4, "R6 readback");
    mailbox_test(8'hC3);
    sweep(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule